// File: doc/BRIEF.md
# Vector Half-Word Multiply-Add Unit

This block executes a single four-operand vector instruction on 128-bit registers. It accepts a 32-bit instruction word with a valid strobe and decodes its primary and extended opcode fields. On a match it reads three source registers from an internal 32-entry by 128-bit register file. It forms eight independent 16-bit results, each the low half-word of a product plus an addend, and writes them to the destination register.

The result is written at the clock edge that ends the accept cycle, and a one-cycle done pulse follows. A word whose opcode fields do not match raises a one-cycle illegal pulse and leaves all state alone. The lane arithmetic wraps silently. There is no saturation, rounding, status or exception output, and signed and unsigned operands give the same bits.

A debug write port and a combinational debug read port let the environment preload and inspect the register file. The active-low asynchronous reset clears only the control outputs; the register contents survive it.

Top module: `vmla_unit`

## Requirements
- R1: A valid word whose bits [31:26] equal 4 and bits [5:0] equal 34 is executed, and done_o is high for exactly the one cycle after the accept cycle. Register fields: destination in [25:21], source A in [20:16], source B in [15:11], source C in [10:6].
- R2: A valid word with any other opcode combination raises illegal_o for exactly the one cycle after acceptance, keeps done_o low, and changes no register.
- R3: Each lane result is (A × B + C) mod 2^16, with operands treated as unsigned 16-bit values. Overflow wraps without any other effect.
- R4: Lane i occupies bits [127−16i : 112−16i] of a register, so lane 0 is the most-significant half-word. No carry or product bit crosses from one lane into another.
- R5: When a source register equals the destination, including destination = A = C, the result uses the register values from before the write.
- R6: While rst_ni is low, done_o and illegal_o are low, and register contents are kept across reset.
- R7: dbg_we_i writes dbg_wdata_i to register dbg_waddr_i at the rising edge. dbg_rdata_o shows register dbg_raddr_i combinationally.
- R8: With instr_valid_i low, done_o and illegal_o stay low in the next cycle and no register changes.
- R9: When a debug write and an instruction write target the same register in one cycle, the instruction result is stored. Writes to different registers both take effect.
- R10: An instruction accepted in the cycle right after another reads that instruction's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| instr_valid_i | input | 1 | Instruction word valid |
| instr_i | input | 32 | Instruction word |
| done_o | output | 1 | One-cycle pulse after an executed instruction |
| illegal_o | output | 1 | One-cycle pulse after an unrecognised word |
| dbg_we_i | input | 1 | Debug register write enable |
| dbg_waddr_i | input | 5 | Debug write register index |
| dbg_wdata_i | input | 128 | Debug write data |
| dbg_raddr_i | input | 5 | Debug read register index |
| dbg_rdata_o | output | 128 | Debug read data |

## Verification
The bench drives all-ones operands so that both the product and the sum wrap. A unit that kept a carry or saturated would leave non-zero or clamped lanes. A pattern with only one lane set catches reversed lane order, because the result then lands in the wrong half-word. Aliased accumulate forms, back-to-back instructions and same-cycle debug writes catch a register file that reads after writing or applies writes in the wrong priority. Near-miss opcodes, with one field correct and the other off by one, catch loose decoding: it would execute those words or corrupt a register instead of flagging them.

// File: rtl/vmla_pkg.sv
package vmla_pkg;
  localparam int unsigned REG_IDX_W = 5;
  localparam logic [5:0] PRIM_OP = 6'd4;
  localparam logic [5:0] EXT_OP  = 6'd34;

  // Field order is MSB first; the struct overlays a 32-bit word directly.
  typedef struct packed {
    logic [5:0]           prim;
    logic [REG_IDX_W-1:0] vd;
    logic [REG_IDX_W-1:0] va;
    logic [REG_IDX_W-1:0] vb;
    logic [REG_IDX_W-1:0] vc;
    logic [5:0]           xo;
  } vinstr_t;
endpackage

// File: rtl/vmla_decode.sv
module vmla_decode
  import vmla_pkg::*;
(
  input  logic [31:0]          instr_i,
  output logic                 match_o,
  output logic [REG_IDX_W-1:0] vd_o,
  output logic [REG_IDX_W-1:0] va_o,
  output logic [REG_IDX_W-1:0] vb_o,
  output logic [REG_IDX_W-1:0] vc_o
);
  vinstr_t f;
  always_comb begin
    f       = vinstr_t'(instr_i);
    match_o = (f.prim == PRIM_OP) && (f.xo == EXT_OP);
    vd_o    = f.vd;
    va_o    = f.va;
    vb_o    = f.vb;
    vc_o    = f.vc;
  end
endmodule

// File: rtl/vmla_regfile.sv
module vmla_regfile #(
  parameter int unsigned NREGS = 32,
  parameter int unsigned WIDTH = 128,
  localparam int unsigned AW   = $clog2(NREGS)
) (
  input  logic             clk_i,
  input  logic [AW-1:0]    ra_i,
  input  logic [AW-1:0]    rb_i,
  input  logic [AW-1:0]    rc_i,
  input  logic [AW-1:0]    rd_dbg_i,
  output logic [WIDTH-1:0] ra_o,
  output logic [WIDTH-1:0] rb_o,
  output logic [WIDTH-1:0] rc_o,
  output logic [WIDTH-1:0] rd_dbg_o,
  input  logic             ex_we_i,
  input  logic [AW-1:0]    ex_waddr_i,
  input  logic [WIDTH-1:0] ex_wdata_i,
  input  logic             dbg_we_i,
  input  logic [AW-1:0]    dbg_waddr_i,
  input  logic [WIDTH-1:0] dbg_wdata_i
);
  logic [WIDTH-1:0] mem [NREGS];

  assign ra_o     = mem[ra_i];
  assign rb_o     = mem[rb_i];
  assign rc_o     = mem[rc_i];
  assign rd_dbg_o = mem[rd_dbg_i];

  // Contents are not reset. The execution write comes last so it wins on a same-address clash.
  always_ff @(posedge clk_i) begin
    if (dbg_we_i) mem[dbg_waddr_i] <= dbg_wdata_i;
    if (ex_we_i)  mem[ex_waddr_i]  <= ex_wdata_i;
  end
endmodule

// File: rtl/vmla_lanes.sv
module vmla_lanes #(
  parameter int unsigned WIDTH  = 128,
  parameter int unsigned LANE_W = 16,
  localparam int unsigned NLANE = WIDTH / LANE_W
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [WIDTH-1:0] c_i,
  output logic [WIDTH-1:0] r_o
);
  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    localparam int unsigned LO = WIDTH - LANE_W*(i+1);
    logic [LANE_W-1:0] a, b, c, prod;
    assign a    = a_i[LO +: LANE_W];
    assign b    = b_i[LO +: LANE_W];
    assign c    = c_i[LO +: LANE_W];
    // Only the low half of the product is ever needed.
    assign prod = a * b;
    assign r_o[LO +: LANE_W] = prod + c;
  end
endmodule

// File: rtl/vmla_unit.sv
module vmla_unit
  import vmla_pkg::*;
#(
  parameter int unsigned NREGS  = 32,
  parameter int unsigned WIDTH  = 128,
  parameter int unsigned LANE_W = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 instr_valid_i,
  input  logic [31:0]          instr_i,
  output logic                 done_o,
  output logic                 illegal_o,
  input  logic                 dbg_we_i,
  input  logic [REG_IDX_W-1:0] dbg_waddr_i,
  input  logic [WIDTH-1:0]     dbg_wdata_i,
  input  logic [REG_IDX_W-1:0] dbg_raddr_i,
  output logic [WIDTH-1:0]     dbg_rdata_o
);
  logic                 match;
  logic [REG_IDX_W-1:0] vd, va, vb, vc;
  logic [WIDTH-1:0]     opa, opb, opc, res;
  logic                 ex_we;

  vmla_decode u_dec (
    .instr_i (instr_i),
    .match_o (match),
    .vd_o    (vd),
    .va_o    (va),
    .vb_o    (vb),
    .vc_o    (vc)
  );

  vmla_regfile #(.NREGS(NREGS), .WIDTH(WIDTH)) u_rf (
    .clk_i       (clk_i),
    .ra_i        (va),
    .rb_i        (vb),
    .rc_i        (vc),
    .rd_dbg_i    (dbg_raddr_i),
    .ra_o        (opa),
    .rb_o        (opb),
    .rc_o        (opc),
    .rd_dbg_o    (dbg_rdata_o),
    .ex_we_i     (ex_we),
    .ex_waddr_i  (vd),
    .ex_wdata_i  (res),
    .dbg_we_i    (dbg_we_i),
    .dbg_waddr_i (dbg_waddr_i),
    .dbg_wdata_i (dbg_wdata_i)
  );

  vmla_lanes #(.WIDTH(WIDTH), .LANE_W(LANE_W)) u_lanes (
    .a_i (opa),
    .b_i (opb),
    .c_i (opc),
    .r_o (res)
  );

  assign ex_we = instr_valid_i && match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o    <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      done_o    <= ex_we;
      illegal_o <= instr_valid_i && !match;
    end
  end
endmodule

// File: rtl/vmla_unit_chk.sv
module vmla_unit_chk #(
  parameter int unsigned WIDTH = 128
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             instr_valid_i,
  input logic [31:0]      instr_i,
  input logic             done_o,
  input logic             illegal_o,
  input logic             dbg_we_i,
  input logic [4:0]       dbg_raddr_i,
  input logic [WIDTH-1:0] dbg_rdata_o
);
  logic hit;
  assign hit = (instr_i[31:26] == 6'd4) && (instr_i[5:0] == 6'd34);

  // R1
  done_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(instr_valid_i && hit));

  // R2
  illegal_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> $past(instr_valid_i && !hit));

  // R2
  excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && illegal_o));

  // R2
  no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_i && !hit && !dbg_we_i) |=>
      ($stable(dbg_raddr_i) -> $stable(dbg_rdata_o)));

  // R8
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !instr_valid_i |=> (!done_o && !illegal_o));
endmodule

bind vmla_unit vmla_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .instr_valid_i (instr_valid_i),
  .instr_i       (instr_i),
  .done_o        (done_o),
  .illegal_o     (illegal_o),
  .dbg_we_i      (dbg_we_i),
  .dbg_raddr_i   (dbg_raddr_i),
  .dbg_rdata_o   (dbg_rdata_o)
);

// File: tb/tb_vmla_unit.sv
module tb_vmla_unit;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         instr_valid_i = 1'b0;
  logic [31:0]  instr_i = '0;
  logic         done_o, illegal_o;
  logic         dbg_we_i = 1'b0;
  logic [4:0]   dbg_waddr_i = '0;
  logic [127:0] dbg_wdata_i = '0;
  logic [4:0]   dbg_raddr_i = '0;
  logic [127:0] dbg_rdata_o;

  int checks = 0;
  int failures = 0;
  logic [127:0] model [32];

  always #5 clk_i = ~clk_i;

  vmla_unit dut (.*);

  function automatic logic [127:0] lanes_fn(logic [127:0] a, logic [127:0] b, logic [127:0] c);
    logic [127:0] r;
    for (int i = 0; i < 8; i++) begin
      logic [31:0] p;
      p = a[127-16*i -: 16] * b[127-16*i -: 16] + c[127-16*i -: 16];
      r[127-16*i -: 16] = p[15:0];
    end
    return r;
  endfunction

  function automatic logic [31:0] mk(int vd, int va, int vb, int vc);
    return {6'd4, 5'(vd), 5'(va), 5'(vb), 5'(vc), 6'd34};
  endfunction

  task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic dbg_wr(int a, logic [127:0] d);
    @(negedge clk_i);
    dbg_we_i = 1; dbg_waddr_i = 5'(a); dbg_wdata_i = d;
    @(negedge clk_i);
    dbg_we_i = 0;
    model[a] = d;
  endtask

  task automatic rd_chk(int a, string req);
    @(negedge clk_i);
    dbg_raddr_i = 5'(a);
    #1;
    chk(dbg_rdata_o === model[a], req, dbg_rdata_o, model[a]);
  endtask

  // Issue one word; checks the pulse shape and updates the model.
  task automatic exec(logic [31:0] w, string req);
    bit legal;
    logic [127:0] r;
    legal = (w[31:26] == 6'd4) && (w[5:0] == 6'd34);
    r = lanes_fn(model[w[20:16]], model[w[15:11]], model[w[10:6]]);
    @(negedge clk_i);
    instr_valid_i = 1; instr_i = w;
    @(posedge clk_i); #1;
    chk(done_o === legal && illegal_o === !legal, req, {done_o, illegal_o}, {legal, !legal});
    @(negedge clk_i);
    instr_valid_i = 0;
    if (legal) model[w[25:21]] = r;
    @(posedge clk_i); #1;
    chk(!done_o && !illegal_o, req, {done_o, illegal_o}, 0);
  endtask

  task automatic all_chk(string req);
    for (int i = 0; i < 32; i++) rd_chk(i, req);
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk_i);
    #1;
    chk(!done_o && !illegal_o, "R6", {done_o, illegal_o}, 0);
    @(negedge clk_i); rst_ni = 1;

    // R7: preload every register with random data
    for (int i = 0; i < 32; i++) dbg_wr(i, {$urandom, $urandom, $urandom, $urandom});
    all_chk("R7");

    // R3: full wrap in every lane
    dbg_wr(1, {8{16'hFFFF}}); dbg_wr(2, {8{16'hFFFF}}); dbg_wr(3, {8{16'hFFFF}});
    exec(mk(4, 1, 2, 3), "R3");
    rd_chk(4, "R3");
    chk(model[4] == 128'd0, "R3", model[4], 0);

    // R4: lane 0 is the top half-word; no carry across lanes
    dbg_wr(1, {16'd2, 112'd0}); dbg_wr(2, {16'd3, 112'd0}); dbg_wr(3, '0);
    exec(mk(5, 1, 2, 3), "R4");
    rd_chk(5, "R4");
    dbg_wr(1, {8{16'hFFFF}}); dbg_wr(2, {8{16'h0001}}); dbg_wr(3, {8{16'h0001}});
    exec(mk(6, 1, 2, 3), "R4");
    rd_chk(6, "R4");
    dbg_wr(1, 128'h0001_0002_0003_0004_0005_0006_0007_0008);
    dbg_wr(2, 128'h0100_0200_0300_0400_0500_0600_0700_0800);
    exec(mk(7, 1, 2, 3), "R4");
    rd_chk(7, "R4");

    // R5: destination aliases A and C (accumulate), then all three sources
    dbg_wr(9, {$urandom, $urandom, $urandom, $urandom});
    dbg_wr(10, {$urandom, $urandom, $urandom, $urandom});
    exec(mk(9, 9, 10, 9), "R5");
    rd_chk(9, "R5");
    exec(mk(10, 10, 10, 10), "R5");
    rd_chk(10, "R5");

    // R2: near-miss opcodes
    exec({6'd4, 5'd11, 5'd1, 5'd2, 5'd3, 6'd35}, "R2");
    exec({6'd5, 5'd11, 5'd1, 5'd2, 5'd3, 6'd34}, "R2");
    all_chk("R2");

    // R10: back-to-back dependent instructions
    begin
      logic [127:0] r1, r2;
      r1 = lanes_fn(model[1], model[2], model[3]);
      r2 = lanes_fn(r1, model[2], model[3]);
      @(negedge clk_i); instr_valid_i = 1; instr_i = mk(12, 1, 2, 3);
      @(negedge clk_i); instr_i = mk(13, 12, 2, 3);
      @(posedge clk_i); #1;
      chk(done_o === 1'b1, "R10", done_o, 1);
      @(negedge clk_i); instr_valid_i = 0;
      model[12] = r1; model[13] = r2;
      rd_chk(12, "R10"); rd_chk(13, "R10");
    end

    // R9: same-cycle debug write, same and different target
    begin
      logic [127:0] r;
      r = lanes_fn(model[1], model[2], model[3]);
      @(negedge clk_i);
      instr_valid_i = 1; instr_i = mk(14, 1, 2, 3);
      dbg_we_i = 1; dbg_waddr_i = 5'd14; dbg_wdata_i = {4{32'hDEADBEEF}};
      @(negedge clk_i);
      instr_valid_i = 0; dbg_we_i = 0;
      model[14] = r;
      rd_chk(14, "R9");
      r = lanes_fn(model[1], model[2], model[3]);
      @(negedge clk_i);
      instr_valid_i = 1; instr_i = mk(15, 1, 2, 3);
      dbg_we_i = 1; dbg_waddr_i = 5'd16; dbg_wdata_i = {4{32'h12345678}};
      @(negedge clk_i);
      instr_valid_i = 0; dbg_we_i = 0;
      model[15] = r; model[16] = {4{32'h12345678}};
      rd_chk(15, "R9"); rd_chk(16, "R9");
    end

    // R8: idle cycles with instruction bits set but valid low
    @(negedge clk_i); instr_i = mk(20, 1, 2, 3);
    repeat (3) begin
      @(posedge clk_i); #1;
      chk(!done_o && !illegal_o, "R8", {done_o, illegal_o}, 0);
    end
    rd_chk(20, "R8");

    // R6: reset in the cycle after an accept; registers retained
    @(negedge clk_i); instr_valid_i = 1; instr_i = mk(21, 1, 2, 3);
    @(negedge clk_i); instr_valid_i = 0; rst_ni = 0;
    model[21] = lanes_fn(model[1], model[2], model[3]);
    #1;
    chk(!done_o && !illegal_o, "R6", {done_o, illegal_o}, 0);
    @(negedge clk_i); rst_ni = 1;
    all_chk("R6");

    // Random mix: R1, R2, R3
    for (int n = 0; n < 200; n++) begin
      int k;
      k = $urandom_range(9, 0);
      if (k < 6) begin
        logic [31:0] w;
        w = mk($urandom_range(31, 0), $urandom_range(31, 0), $urandom_range(31, 0), $urandom_range(31, 0));
        exec(w, "R1");
        rd_chk(w[25:21], "R3");
      end else if (k < 8) begin
        logic [31:0] w;
        w = $urandom;
        if (w[31:26] == 6'd4 && w[5:0] == 6'd34) w[0] = ~w[0];
        exec(w, "R2");
        rd_chk(w[25:21], "R2");
      end else begin
        dbg_wr($urandom_range(31, 0), {$urandom, $urandom, $urandom, $urandom});
      end
    end
    all_chk("R1");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule